// File: doc/BRIEF.md
# Direct-Mapped Read Cache Controller

This block is a small read-only data cache. It sits between a processor read port and a 4 kB byte-addressed memory that delivers data in bursts. The processor presents a 12-bit byte address with a one-cycle read strobe. Some cycles later the block returns the addressed 32-bit word with a one-cycle ready pulse. The cache stores four lines of two words each. Each memory line can live in exactly one cache line, chosen from the low bits of its line number.

A lookup compares the stored tag and valid bit of the selected line with the request. When the line is resident, the word comes from local storage. When it is not, the block asks the memory for the whole line as one burst. It writes both beats into the line and answers the processor after the last beat. Every lookup is sorted into one of three classes: a first touch of an empty line, a replacement of another memory line that mapped to the same place, or a hit. A saturating counter per class records the traffic, and a clear pulse resets all three counters.

Top module: `dmcache_ctrl`

## Requirements
- R1: The byte address is decoded with bits 11:5 as the tag, bits 4:3 as the cache line, bit 2 as the word within the line, and bits 1:0 ignored. Two addresses that differ only in bits 1:0 return the same word.
- R2: After reset, all three counters read 0, cpu_ready and mem_req are low, and every line is empty, so the first access to any line is a cold miss.
- R3: On a hit, cpu_ready is high for exactly one cycle, two cycles after the strobe cycle. cpu_data then holds the addressed word, and no memory request is made.
- R4: On a miss, mem_req pulses for one cycle in the cycle after the lookup. mem_addr then gives the line base address, which is the request with bits 2:0 cleared. The memory returns word 0 and then word 1 on consecutive mem_valid beats. cpu_ready pulses in the cycle after the second beat and carries the requested word. With a memory answering in 3+1 cycles, this is six cycles after the strobe cycle.
- R5: After a refill, both words of the line are resident, so an access to the other word of the same line hits.
- R6: Each accepted lookup increments exactly one counter. The cold counter counts accesses to an empty line. The conflict counter counts accesses to a valid line with a different tag. The hit counter counts accesses to a valid line with the same tag.
- R7: Running the address sequence 0x010, 0x1FC, 0x168, 0x008, 0x014, 0x1F8, 0x00C from reset classifies as cold, cold, cold, conflict, hit, hit, hit. Each later repetition classifies as hit, hit, conflict, conflict, hit, hit, hit.
- R8: Each counter saturates at its all-ones value and never wraps.
- R9: A one-cycle cnt_clr pulse zeroes all three counters in the next cycle. It takes priority over a simultaneous count and leaves the cache contents unchanged.
- R10: A read strobe raised while a lookup or refill is in progress is ignored. It produces no extra ready pulse, no memory request and no count, and it does not install its line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_rd | input | 1 | Read strobe, one cycle, accepted when idle |
| cpu_addr | input | 12 | Byte address of the read |
| cpu_ready | output | 1 | One-cycle pulse: cpu_data is valid |
| cpu_data | output | 32 | Returned word |
| mem_req | output | 1 | One-cycle line refill request |
| mem_addr | output | 12 | Line base byte address of the refill |
| mem_valid | input | 1 | Memory beat valid |
| mem_data | input | 32 | Memory beat data, word 0 first |
| cnt_clr | input | 1 | Clears the three counters |
| cnt_hit | output | 16 | Hit count |
| cnt_cold | output | 16 | Cold miss count |
| cnt_conf | output | 16 | Conflict miss count |

## Verification
The hardest case to reach is a read strobe that arrives while a refill burst is in flight. The bench deliberately raises a second strobe in the middle of a miss, aimed at a line that would otherwise miss. It then checks that only one answer appears, that only one memory request is made and that no count changes for the second strobe. A later access to the ignored address must still take the full miss latency. Saturation is reached by repeating hits on a resident line more than 255 times, with the counters built 8 bits wide for the bench. Reaching the 16-bit limit would take far more accesses.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_FILL = 2'd2
  } dmc_state_e;

  // event vector positions for the counter bank
  localparam int EV_HIT  = 0;
  localparam int EV_COLD = 1;
  localparam int EV_CONF = 2;
  localparam int EV_NUM  = 3;

endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
  parameter int LINES = 4,
  parameter int TAG_W = 7,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_valid,
  output logic             lk_match,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag
);

  logic [LINES-1:0] valid_q, valid_d;
  logic [TAG_W-1:0] tag_q [LINES];

  always_comb begin
    valid_d = valid_q;
    if (wr_en) valid_d[wr_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     valid_q <= '0;
    else if (wr_en) valid_q <= valid_d;
  end

  for (genvar i = 0; i < LINES; i++) begin : g_tag
    always_ff @(posedge clk) begin
      if (wr_en && (wr_idx == IDX_W'(i))) tag_q[i] <= wr_tag;
    end
  end

  assign lk_valid = valid_q[lk_idx];
  assign lk_match = (tag_q[lk_idx] == lk_tag);

endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
  parameter int LINES  = 4,
  parameter int WPL    = 2,
  parameter int WORD_W = 32,
  localparam int IDX_W = $clog2(LINES),
  localparam int OFF_W = $clog2(WPL),
  localparam int DEPTH = LINES * WPL
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_line,
  input  logic [OFF_W-1:0]  wr_word,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_line,
  input  logic [OFF_W-1:0]  rd_word,
  output logic [WORD_W-1:0] rd_data
);

  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[{wr_line, wr_word}] <= wr_data;
  end

  assign rd_data = mem_q[{rd_line, rd_word}];

endmodule

// File: rtl/dmc_counters.sv
module dmc_counters #(
  parameter int N     = 3,
  parameter int CNT_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  input  logic [N-1:0]              evt,
  output logic [N-1:0][CNT_W-1:0]   cnt
);

  for (genvar i = 0; i < N; i++) begin : g_cnt
    logic [CNT_W-1:0] c_q, c_d;
    logic             c_en;

    always_comb begin
      c_en = clr | (evt[i] & (c_q != {CNT_W{1'b1}}));
      c_d  = clr ? '0 : c_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    c_q <= '0;
      else if (c_en) c_q <= c_d;
    end

    assign cnt[i] = c_q;
  end

endmodule

// File: rtl/dmc_seq.sv
module dmc_seq
  import dmc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int WORD_W = 32,
  parameter int LINES  = 4,
  parameter int WPL    = 2,
  localparam int BYTE_W = $clog2(WORD_W / 8),
  localparam int OFF_W  = $clog2(WPL),
  localparam int IDX_W  = $clog2(LINES),
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W - BYTE_W,
  localparam int WA_W   = ADDR_W - BYTE_W,
  localparam int LINE_LSB = BYTE_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_rd,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              cpu_ready,
  output logic [WORD_W-1:0] cpu_data,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_valid,
  input  logic [WORD_W-1:0] mem_data,
  output logic [IDX_W-1:0]  lk_idx,
  output logic [TAG_W-1:0]  lk_tag,
  input  logic              lk_valid,
  input  logic              lk_match,
  output logic              tag_we,
  output logic              ds_we,
  output logic [OFF_W-1:0]  ds_wr_word,
  output logic [OFF_W-1:0]  ds_rd_word,
  input  logic [WORD_W-1:0] ds_rd_data,
  output logic [EV_NUM-1:0] evt
);

  localparam logic [OFF_W-1:0] LAST_BEAT = OFF_W'(WPL - 1);

  dmc_state_e        state_q, state_d;
  logic [WA_W-1:0]   req_q;
  logic              req_en;
  logic [OFF_W-1:0]  beat_q, beat_d;
  logic              beat_en;
  logic [WORD_W-1:0] rdata_q, rdata_d;
  logic              rdata_en;
  logic              ready_q, ready_d;
  logic              mreq_q, mreq_d;
  logic [OFF_W-1:0]  req_word;
  logic              unused_byte_bits;

  assign unused_byte_bits = ^cpu_addr[BYTE_W-1:0];

  assign req_word = req_q[OFF_W-1:0];
  assign lk_idx   = req_q[OFF_W +: IDX_W];
  assign lk_tag   = req_q[WA_W-1 -: TAG_W];

  // next-state process
  always_comb begin
    state_d  = state_q;
    req_en   = 1'b0;
    beat_d   = beat_q;
    beat_en  = 1'b0;
    rdata_d  = rdata_q;
    rdata_en = 1'b0;
    ready_d  = 1'b0;
    mreq_d   = 1'b0;
    tag_we   = 1'b0;
    ds_we    = 1'b0;
    evt      = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (cpu_rd) begin
          req_en  = 1'b1;
          state_d = ST_LOOK;
        end
      end
      ST_LOOK: begin
        if (lk_valid && lk_match) begin
          evt[EV_HIT] = 1'b1;
          ready_d     = 1'b1;
          rdata_d     = ds_rd_data;
          rdata_en    = 1'b1;
          state_d     = ST_IDLE;
        end else begin
          if (lk_valid) evt[EV_CONF] = 1'b1;
          else          evt[EV_COLD] = 1'b1;
          mreq_d  = 1'b1;
          beat_d  = '0;
          beat_en = 1'b1;
          state_d = ST_FILL;
        end
      end
      ST_FILL: begin
        if (mem_valid) begin
          ds_we   = 1'b1;
          beat_d  = beat_q + OFF_W'(1);
          beat_en = 1'b1;
          if (beat_q == LAST_BEAT) begin
            tag_we   = 1'b1;
            ready_d  = 1'b1;
            rdata_en = 1'b1;
            rdata_d  = (beat_q == req_word) ? mem_data : ds_rd_data;
            state_d  = ST_IDLE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ready_q <= 1'b0;
      mreq_q  <= 1'b0;
      rdata_q <= '0;
      beat_q  <= '0;
      req_q   <= '0;
    end else begin
      state_q <= state_d;
      ready_q <= ready_d;
      mreq_q  <= mreq_d;
      if (rdata_en) rdata_q <= rdata_d;
      if (beat_en)  beat_q  <= beat_d;
      if (req_en)   req_q   <= cpu_addr[ADDR_W-1:BYTE_W];
    end
  end

  assign cpu_ready  = ready_q;
  assign cpu_data   = rdata_q;
  assign mem_req    = mreq_q;
  assign mem_addr   = {req_q[WA_W-1:OFF_W], {LINE_LSB{1'b0}}};
  assign ds_wr_word = beat_q;
  assign ds_rd_word = req_word;

endmodule

// File: rtl/dmcache_ctrl.sv
module dmcache_ctrl
  import dmc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int WORD_W = 32,
  parameter int LINES  = 4,
  parameter int WPL    = 2,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_rd,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              cpu_ready,
  output logic [WORD_W-1:0] cpu_data,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_valid,
  input  logic [WORD_W-1:0] mem_data,
  input  logic              cnt_clr,
  output logic [CNT_W-1:0]  cnt_hit,
  output logic [CNT_W-1:0]  cnt_cold,
  output logic [CNT_W-1:0]  cnt_conf
);

  localparam int BYTE_W = $clog2(WORD_W / 8);
  localparam int OFF_W  = $clog2(WPL);
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W - BYTE_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [IDX_W-1:0]            lk_idx;
  logic [TAG_W-1:0]            lk_tag;
  logic                        lk_valid, lk_match;
  logic                        tag_we, ds_we;
  logic [OFF_W-1:0]            ds_wr_word, ds_rd_word;
  logic [WORD_W-1:0]           ds_rd_data;
  logic [EV_NUM-1:0]           evt;
  logic [EV_NUM-1:0][CNT_W-1:0] cnt;

  dmc_seq #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .LINES(LINES), .WPL(WPL)
  ) seq_i (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .cpu_rd     (cpu_rd),
    .cpu_addr   (cpu_addr),
    .cpu_ready  (cpu_ready),
    .cpu_data   (cpu_data),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_valid  (mem_valid),
    .mem_data   (mem_data),
    .lk_idx     (lk_idx),
    .lk_tag     (lk_tag),
    .lk_valid   (lk_valid),
    .lk_match   (lk_match),
    .tag_we     (tag_we),
    .ds_we      (ds_we),
    .ds_wr_word (ds_wr_word),
    .ds_rd_word (ds_rd_word),
    .ds_rd_data (ds_rd_data),
    .evt        (evt)
  );

  dmc_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) tags_i (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .lk_idx   (lk_idx),
    .lk_tag   (lk_tag),
    .lk_valid (lk_valid),
    .lk_match (lk_match),
    .wr_en    (tag_we),
    .wr_idx   (lk_idx),
    .wr_tag   (lk_tag)
  );

  dmc_data_store #(.LINES(LINES), .WPL(WPL), .WORD_W(WORD_W)) data_i (
    .clk     (clk),
    .wr_en   (ds_we),
    .wr_line (lk_idx),
    .wr_word (ds_wr_word),
    .wr_data (mem_data),
    .rd_line (lk_idx),
    .rd_word (ds_rd_word),
    .rd_data (ds_rd_data)
  );

  dmc_counters #(.N(EV_NUM), .CNT_W(CNT_W)) cnt_i (
    .clk   (clk),
    .rst_n (rst_int_n),
    .clr   (cnt_clr),
    .evt   (evt),
    .cnt   (cnt)
  );

  assign cnt_hit  = cnt[EV_HIT];
  assign cnt_cold = cnt[EV_COLD];
  assign cnt_conf = cnt[EV_CONF];

endmodule

// File: rtl/dmcache_ctrl_chk.sv
module dmcache_ctrl_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_ready,
  input logic             mem_req,
  input logic             cnt_clr,
  input logic [CNT_W-1:0] cnt_hit,
  input logic [CNT_W-1:0] cnt_cold,
  input logic [CNT_W-1:0] cnt_conf
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  assert_ready_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready);

  assert_req_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  assert_req_not_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && cpu_ready));

  assert_one_class_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cnt_clr) |-> $onehot0({cnt_hit != $past(cnt_hit),
                                  cnt_cold != $past(cnt_cold),
                                  cnt_conf != $past(cnt_conf)}));

  assert_hit_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cnt_clr) && (cnt_hit != $past(cnt_hit))) |-> (cnt_hit == $past(cnt_hit) + ONE));

  assert_hit_sat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt_hit == TOP) && !cnt_clr) |=> (cnt_hit == TOP));

  assert_cold_sat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt_cold == TOP) && !cnt_clr) |=> (cnt_cold == TOP));

  assert_conf_sat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt_conf == TOP) && !cnt_clr) |=> (cnt_conf == TOP));

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> ((cnt_hit == '0) && (cnt_cold == '0) && (cnt_conf == '0)));

endmodule

bind dmcache_ctrl dmcache_ctrl_chk #(.CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_ready (cpu_ready),
  .mem_req   (mem_req),
  .cnt_clr   (cnt_clr),
  .cnt_hit   (cnt_hit),
  .cnt_cold  (cnt_cold),
  .cnt_conf  (cnt_conf)
);

// File: tb/dmcache_ctrl_tb_top.sv
module dmcache_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int TB_CNT_W   = 8;
  localparam int CNT_MAX    = (1 << TB_CNT_W) - 1;
  localparam int CL_HIT = 0, CL_COLD = 1, CL_CONF = 2, CL_UNK = 3;

  logic                clk, rst_n;
  logic                cpu_rd;
  logic [11:0]         cpu_addr;
  logic                cpu_ready;
  logic [31:0]         cpu_data;
  logic                mem_req;
  logic [11:0]         mem_addr;
  logic                mem_valid;
  logic [31:0]         mem_data;
  logic                cnt_clr;
  logic [TB_CNT_W-1:0] cnt_hit, cnt_cold, cnt_conf;

  int total = 0, bad = 0;
  int req_seen = 0, rdy_seen = 0;
  logic [11:0] last_req_addr = '0;

  // reference model state
  bit       mv [4];
  bit [6:0] mt [4];
  int ehit = 0, ecold = 0, econf = 0;

  dmcache_ctrl #(.CNT_W(TB_CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_addr(cpu_addr),
    .cpu_ready(cpu_ready), .cpu_data(cpu_data), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_data(mem_data),
    .cnt_clr(cnt_clr), .cnt_hit(cnt_hit), .cnt_cold(cnt_cold), .cnt_conf(cnt_conf)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [31:0] mem_word(input logic [11:0] a);
    return {4'hD, a[11:2], 8'h3C, a[11:2]};
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic sat_inc(inout int c);
    if (c < CNT_MAX) c++;
  endtask

  task automatic chk_counts(input string rq);
    chk(cnt_hit  == TB_CNT_W'(ehit),  rq, "hit count",  cnt_hit,  ehit);
    chk(cnt_cold == TB_CNT_W'(ecold), rq, "cold count", cnt_cold, ecold);
    chk(cnt_conf == TB_CNT_W'(econf), rq, "conf count", cnt_conf, econf);
  endtask

  // burst memory: first beat 3 cycles after request cycle start (req, wait, data), second next
  initial begin
    mem_valid = 1'b0;
    mem_data  = '0;
    forever begin
      @(negedge clk);
      if (mem_req === 1'b1) begin
        automatic logic [11:0] base = mem_addr;
        last_req_addr = base;
        req_seen++;
        @(negedge clk);
        @(negedge clk);
        mem_valid = 1'b1;
        mem_data  = mem_word(base);
        @(negedge clk);
        mem_data  = mem_word(base + 12'd4);
        @(negedge clk);
        mem_valid = 1'b0;
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (cpu_ready === 1'b1) rdy_seen++;
    end
  end

  // one read; returns classification seen at the counters and latency
  task automatic do_access(input logic [11:0] a, output int dcls, output int lat);
    int mcls, q0, elat;
    logic [TB_CNT_W-1:0] h0, c0, f0;
    logic [31:0] got;
    bit [1:0] idx;
    bit [6:0] tg;
    idx = a[4:3];
    tg  = a[11:5];
    mcls = !mv[idx] ? CL_COLD : (mt[idx] != tg) ? CL_CONF : CL_HIT;
    elat = (mcls == CL_HIT) ? 2 : 6;
    @(negedge clk);
    q0 = req_seen; h0 = cnt_hit; c0 = cnt_cold; f0 = cnt_conf;
    cpu_rd = 1'b1; cpu_addr = a;
    @(negedge clk);
    cpu_rd = 1'b0;
    lat = 1;
    while (cpu_ready !== 1'b1 && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    got = cpu_data;
    if (cnt_hit != h0)       dcls = CL_HIT;
    else if (cnt_cold != c0) dcls = CL_COLD;
    else if (cnt_conf != f0) dcls = CL_CONF;
    else                     dcls = CL_UNK;
    mv[idx] = 1'b1; mt[idx] = tg;
    if (mcls == CL_HIT)       sat_inc(ehit);
    else if (mcls == CL_COLD) sat_inc(ecold);
    else                      sat_inc(econf);
    if (mcls == CL_HIT) begin
      chk(lat == elat, "R3", "hit latency", lat, elat);
      chk(req_seen == q0, "R3", "hit mem requests", req_seen - q0, 0);
    end else begin
      chk(lat == elat, "R4", "miss latency", lat, elat);
      chk(req_seen == q0 + 1, "R4", "miss mem requests", req_seen - q0, 1);
      chk(last_req_addr == {a[11:3], 3'b000}, "R4", "refill address",
          last_req_addr, {a[11:3], 3'b000});
    end
    chk(got == mem_word({a[11:2], 2'b00}), "R1", "returned word", got, mem_word({a[11:2], 2'b00}));
    chk_counts("R6");
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int dc, lt;
    logic [11:0] seq [7];
    int exp1 [7];
    int expn [7];
    seq = '{12'h010, 12'h1FC, 12'h168, 12'h008, 12'h014, 12'h1F8, 12'h00C};
    exp1 = '{CL_COLD, CL_COLD, CL_COLD, CL_CONF, CL_HIT, CL_HIT, CL_HIT};
    expn = '{CL_HIT, CL_HIT, CL_CONF, CL_CONF, CL_HIT, CL_HIT, CL_HIT};
    for (int i = 0; i < 4; i++) begin mv[i] = 1'b0; mt[i] = '0; end
    cpu_rd = 1'b0; cpu_addr = '0; cnt_clr = 1'b0; rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 reset state
    chk(cpu_ready == 1'b0, "R2", "ready after reset", cpu_ready, 0);
    chk(mem_req == 1'b0, "R2", "mem_req after reset", mem_req, 0);
    chk_counts("R2");

    // R7 reference sequence, three passes
    for (int p = 0; p < 3; p++) begin
      for (int i = 0; i < 7; i++) begin
        do_access(seq[i], dc, lt);
        chk(dc == ((p == 0) ? exp1[i] : expn[i]), "R7", "classification",
            dc, (p == 0) ? exp1[i] : expn[i]);
      end
    end
    chk(ecold == 3 && econf == 5 && ehit == 13, "R7", "pass totals", ecold * 256 + econf, 3 * 256 + 5);

    // R1 byte offset bits are ignored: same word, hit
    for (int b = 1; b < 4; b++) begin
      do_access(12'h010 | 12'(b), dc, lt);
      chk(dc == CL_HIT, "R1", "byte offset hit", dc, CL_HIT);
    end

    // R9 clear, then R5 sweep of every memory line, both words
    @(negedge clk); cnt_clr = 1'b1;
    @(negedge clk); cnt_clr = 1'b0;
    ehit = 0; ecold = 0; econf = 0;
    chk_counts("R9");
    for (int l = 0; l < 512; l++) begin
      automatic logic [11:0] a0 = 12'(l * 8 + ((l % 2 == 1) ? 4 : 0));
      do_access(a0, dc, lt);
      do_access(a0 ^ 12'h004, dc, lt);
      chk(lt == 2, "R5", "other word resident", lt, 2);
    end

    // R9 clear keeps contents: resident line still hits
    @(negedge clk); cnt_clr = 1'b1;
    @(negedge clk); cnt_clr = 1'b0;
    ehit = 0; ecold = 0; econf = 0;
    chk_counts("R9");
    do_access(12'hFF8, dc, lt);
    chk(dc == CL_HIT && cnt_hit == 1, "R9", "hit after clear", cnt_hit, 1);

    // R8 saturation
    for (int k = 0; k < 300; k++) do_access(12'hFFC, dc, lt);
    chk(cnt_hit == TB_CNT_W'(CNT_MAX), "R8", "hit saturated", cnt_hit, CNT_MAX);

    // R10 strobe during refill is ignored
    begin
      int r0, q0, lat;
      logic [TB_CNT_W-1:0] c0, f0, h0;
      @(negedge clk);
      r0 = rdy_seen; q0 = req_seen; c0 = cnt_cold; f0 = cnt_conf; h0 = cnt_hit;
      cpu_rd = 1'b1; cpu_addr = 12'h800;
      @(negedge clk); cpu_rd = 1'b0;
      @(negedge clk);
      @(negedge clk); cpu_rd = 1'b1; cpu_addr = 12'h908;
      @(negedge clk); cpu_rd = 1'b0;
      lat = 4;
      while (cpu_ready !== 1'b1 && lat < 40) begin @(negedge clk); lat++; end
      chk(lat == 6, "R10", "first miss latency", lat, 6);
      chk(cpu_data == mem_word(12'h800), "R10", "first miss data", cpu_data, mem_word(12'h800));
      repeat (12) @(negedge clk);
      chk(rdy_seen == r0 + 1, "R10", "ready pulses", rdy_seen - r0, 1);
      chk(req_seen == q0 + 1, "R10", "mem requests", req_seen - q0, 1);
      chk(cnt_conf == f0 + 1 && cnt_cold == c0 && cnt_hit == h0, "R10", "single count",
          cnt_conf - f0, 1);
      mv[0] = 1'b1; mt[0] = 7'h40; sat_inc(econf);
      do_access(12'h908, dc, lt);
      chk(lt == 6, "R10", "ignored line not installed", lt, 6);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule